// File: doc/BRIEF.md
# CAN Node Fault Confinement Counters

This block keeps the two error counters of a CAN controller, one for transmit-side faults and one for receive-side faults, and derives from them the node's confinement state: error-active, error-passive or bus-off. The protocol engine feeds it single-cycle event pulses. These report a transmit error (an acknowledge failure is reported here too), a receive error, a frame sent without error, a frame received without error, and one pulse for each run of 11 recessive bits seen while the node is off the bus. The block does not detect errors itself and does no bit-level work.

Transmit faults cost eight times as much as receive faults, and every clean frame takes one point back. A node that keeps causing errors therefore silences itself quickly, while a node that only witnesses errors climbs slowly. Once the node is off the bus the counters freeze. The node returns to the bus only after a fixed number of recessive-run pulses, and at that point both counters clear.

Top module: `can_fault_conf`

## Requirements
- R1: A `tx_err` pulse adds 8 to `tec`, a 9-bit counter that saturates at 511 and so can hold values above 255.
- R2: An `rx_err` pulse adds 1 to `rec`, an 8-bit counter that saturates at 255.
- R3: A `tx_ok` pulse subtracts 1 from `tec` and an `rx_ok` pulse subtracts 1 from `rec`. Neither counter ever goes below 0.
- R4: `state` is encoded as 2'b00 error-active, 2'b01 error-passive and 2'b10 bus-off. Outside bus-off it reads error-passive when `tec` >= 128 or `rec` >= 128, and error-active otherwise (for example `tec` = 116 with `rec` < 128).
- R5: Bus-off holds exactly when `tec` > 255. With `tec` = 255 the node is error-passive. Starting from 231, three errors give 255 (passive) and a fourth gives 263 (bus-off).
- R6: While in bus-off, `tx_err`, `rx_err`, `tx_ok` and `rx_ok` change neither counter.
- R7: In bus-off, the 128th `idle_seq` pulse since bus-off was entered sets both counters to 0, and `state` reads error-active on the next cycle. `idle_seq` pulses outside bus-off have no effect and do not count toward recovery.
- R8: When an error pulse and a success pulse for the same counter arrive in the same cycle, only the error increment is applied.
- R9: After synchronous reset both counters are 0 and `state` is error-active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err | input | 1 | Transmit error pulse (including acknowledge failure) |
| rx_err | input | 1 | Receive error pulse |
| tx_ok | input | 1 | Frame transmitted successfully |
| rx_ok | input | 1 | Frame received successfully |
| idle_seq | input | 1 | One run of 11 recessive bits observed |
| tec | output | 9 | Transmit error count |
| rec | output | 8 | Receive error count |
| state | output | 2 | Confinement state (00 active, 01 passive, 10 bus-off) |

## Verification
The collisions that matter are an error pulse and a success pulse for the same counter landing in one cycle. The second is a recessive-run pulse arriving in the same cycle that fault pulses are ignored because the node is off the bus. The bench raises all five inputs together, in many combinations, from a linear-feedback generator whose bias shifts across phases, so that every confinement state is visited. After each cycle it compares both counters and the state with an arithmetic model built from the requirements. Directed sequences then hit the exact 255/256 boundary, the 127th and 128th recovery pulses, and recessive-run pulses that arrive before bus-off.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;

    localparam int FC_TEC_W     = 9;
    localparam int FC_REC_W     = 8;
    localparam int FC_TX_STEP   = 8;
    localparam int FC_RX_STEP   = 1;
    localparam int FC_PASS_LIM  = 128;
    localparam int FC_OFF_LIM   = 255;
    localparam int FC_RECOVER_N = 128;

    typedef struct packed {
        logic up;
        logic down;
    } fc_evt_t;

    function automatic fc_evt_t fc_resolve(input logic err, input logic ok);
        fc_evt_t e;
        e.up   = err;
        e.down = ok & ~err;
        return e;
    endfunction

endpackage

// File: rtl/fc_sat_counter.sv
module fc_sat_counter #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  fc_pkg::fc_evt_t evt,
    output logic [W-1:0] cnt
);
    localparam logic [W:0] MAXV   = {1'b0, {W{1'b1}}};
    localparam logic [W:0] STEP_V = (W+1)'(STEP);

    logic [W:0] sum;
    assign sum = {1'b0, cnt} + STEP_V;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!hold) begin
            if (evt.up) begin
                cnt <= (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
            end else if (evt.down && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fc_state_dec.sv
module fc_state_dec #(
    parameter int TEC_W    = 9,
    parameter int REC_W    = 8,
    parameter int PASS_LIM = 128,
    parameter int OFF_LIM  = 255
) (
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    output fc_pkg::fc_state_e st,
    output logic             bus_off
);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(OFF_LIM);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASS_LIM);

    always_comb begin
        bus_off = (tec > TEC_OFF);
        if (bus_off) begin
            st = fc_pkg::FC_BUSOFF;
        end else if ((tec >= TEC_PASS) || (rec >= REC_PASS)) begin
            st = fc_pkg::FC_PASSIVE;
        end else begin
            st = fc_pkg::FC_ACTIVE;
        end
    end
endmodule

// File: rtl/fc_busoff_recovery.sv
module fc_busoff_recovery #(
    parameter int LIM = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_off,
    input  logic idle_seq,
    output logic clr_all
);
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] seen;

    assign clr_all = bus_off && idle_seq && (seen == LAST);

    always_ff @(posedge clk) begin
        if (rst || !bus_off || clr_all) begin
            seen <= '0;
        end else if (idle_seq) begin
            seen <= seen + 1'b1;
        end
    end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int TEC_W     = fc_pkg::FC_TEC_W,
    parameter int REC_W     = fc_pkg::FC_REC_W,
    parameter int TX_STEP   = fc_pkg::FC_TX_STEP,
    parameter int RX_STEP   = fc_pkg::FC_RX_STEP,
    parameter int PASS_LIM  = fc_pkg::FC_PASS_LIM,
    parameter int OFF_LIM   = fc_pkg::FC_OFF_LIM,
    parameter int RECOVER_N = fc_pkg::FC_RECOVER_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             idle_seq,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic [1:0]       state
);
    import fc_pkg::*;

    fc_state_e st;
    logic      bus_off;
    logic      clr_all;
    fc_evt_t   tx_evt;
    fc_evt_t   rx_evt;

    // error wins over success for the same counter (R8)
    assign tx_evt = fc_resolve(tx_err, tx_ok);
    assign rx_evt = fc_resolve(rx_err, rx_ok);

    fc_sat_counter #(.W(TEC_W), .STEP(TX_STEP)) u_tec (
        .clk(clk), .rst(rst), .clr(clr_all), .hold(bus_off),
        .evt(tx_evt), .cnt(tec)
    );

    fc_sat_counter #(.W(REC_W), .STEP(RX_STEP)) u_rec (
        .clk(clk), .rst(rst), .clr(clr_all), .hold(bus_off),
        .evt(rx_evt), .cnt(rec)
    );

    fc_state_dec #(
        .TEC_W(TEC_W), .REC_W(REC_W), .PASS_LIM(PASS_LIM), .OFF_LIM(OFF_LIM)
    ) u_dec (
        .tec(tec), .rec(rec), .st(st), .bus_off(bus_off)
    );

    fc_busoff_recovery #(.LIM(RECOVER_N)) u_recov (
        .clk(clk), .rst(rst), .bus_off(bus_off), .idle_seq(idle_seq),
        .clr_all(clr_all)
    );

    assign state = st;
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
    parameter int TEC_W   = 9,
    parameter int REC_W   = 8,
    parameter int TX_STEP = 8,
    parameter int OFF_LIM = 255
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_err,
    input logic             rx_err,
    input logic             tx_ok,
    input logic             rx_ok,
    input logic             idle_seq,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic [1:0]       state
);
    localparam logic [TEC_W-1:0] T_OFF  = TEC_W'(OFF_LIM);
    localparam logic [TEC_W-1:0] T_STEP = TEC_W'(TX_STEP);
    localparam logic [REC_W-1:0] R_MAX  = {REC_W{1'b1}};

    p_tx_add_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_err && tec <= T_OFF) |=> (tec == $past(tec) + T_STEP));

    p_rx_add_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_err && tec <= T_OFF && rec != R_MAX) |=> (rec == $past(rec) + 1'b1));

    p_tx_heal_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && !tx_err && tec <= T_OFF && tec != '0) |=> (tec == $past(tec) - 1'b1));

    p_rx_heal_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && rx_err && tec <= T_OFF && rec != R_MAX) |=> (rec > $past(rec)));

    p_busoff_code_r5: assert property (@(posedge clk) disable iff (rst)
        (tec > T_OFF) |-> (state == 2'b10));

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && !idle_seq) |=> ($stable(tec) && $stable(rec)));

    p_legal_code_r4: assert property (@(posedge clk) disable iff (rst)
        (state != 2'b11));
endmodule

bind can_fault_conf can_fault_conf_chk #(
    .TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP), .OFF_LIM(OFF_LIM)
) u_chk (
    .clk(clk), .rst(rst), .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok),
    .rx_ok(rx_ok), .idle_seq(idle_seq), .tec(tec), .rec(rec), .state(state)
);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic tx_err, rx_err, tx_ok, rx_ok, idle_seq;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;

    int total = 0;
    int bad   = 0;
    int m_tec, m_rec, m_rcv;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_fault_conf u_dut (
        .clk(clk), .rst(rst), .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok),
        .rx_ok(rx_ok), .idle_seq(idle_seq), .tec(tec), .rec(rec), .state(state)
    );

    function automatic int exp_state();
        if (m_tec > 255) return 2;
        if (m_tec >= 128 || m_rec >= 128) return 1;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, int'(tec), m_tec, "tec");
        check(req, int'(rec), m_rec, "rec");
        check(req, int'(state), exp_state(), "state");
    endtask

    // drive at negedge, clock, update model, sample at the following negedge
    task automatic step(input bit te, input bit re, input bit to, input bit ro, input bit id);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; idle_seq = id;
        @(posedge clk);
        if (m_tec > 255) begin
            if (id) begin
                m_rcv++;
                if (m_rcv == 128) begin m_tec = 0; m_rec = 0; m_rcv = 0; end
            end
        end else begin
            m_rcv = 0;
            if (te) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
            else if (to && m_tec > 0) m_tec--;
            if (re) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
            else if (ro && m_rec > 0) m_rec--;
        end
        @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle_seq = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle_seq = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_tec = 0; m_rec = 0; m_rcv = 0;
    endtask

    initial begin
        do_reset();
        check_all("R9");

        // R1 and R4: climb to error-passive in 16 transmit errors
        for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 0);
        check_all("R1");
        check(  "R4", int'(state), 0, "state at tec 120");
        step(1, 0, 0, 0, 0);
        check(  "R4", int'(state), 1, "state at tec 128");
        // R4: heal 12 times back to error-active (116)
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 0);
        check(  "R4", int'(tec), 116, "tec healed");
        check(  "R4", int'(state), 0, "state healed");

        // R8: simultaneous error and success
        step(1, 1, 1, 1, 0);
        check_all("R8");
        // R3: floor at zero for rec
        do_reset();
        step(0, 0, 1, 1, 0);
        check(  "R3", int'(tec), 0, "tec floor");
        check(  "R3", int'(rec), 0, "rec floor");

        // R2: receive errors up to passive and saturation
        for (int i = 0; i < 128; i++) step(0, 1, 0, 0, 0);
        check(  "R2", int'(rec), 128, "rec after 128");
        check(  "R4", int'(state), 1, "passive by rec");
        for (int i = 0; i < 140; i++) step(0, 1, 0, 0, 0);
        check(  "R2", int'(rec), 255, "rec saturated");

        // R5: 231 then three errors -> 255 passive, fourth -> 263 bus-off
        do_reset();
        for (int i = 0; i < 29; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        check(  "R5", int'(tec), 231, "tec start");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
        check(  "R5", int'(tec), 255, "tec at 255");
        check(  "R5", int'(state), 1, "passive at 255");
        // R7: idle pulses outside bus-off do not count
        for (int i = 0; i < 100; i++) step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0);
        check(  "R5", int'(tec), 263, "tec at 263");
        check(  "R5", int'(state), 2, "bus-off");

        // R6: all fault and success pulses ignored in bus-off
        step(1, 1, 1, 1, 0);
        check(  "R6", int'(tec), 263, "tec frozen");
        check(  "R6", int'(rec), 0, "rec frozen");
        check(  "R6", int'(state), 2, "still bus-off");

        // R7: 127 pulses keep bus-off, 128th recovers
        for (int i = 0; i < 127; i++) step(1, 1, 0, 0, 1);
        check(  "R7", int'(state), 2, "bus-off after 127");
        check(  "R7", int'(tec), 263, "tec held after 127");
        step(0, 0, 0, 0, 1);
        check(  "R7", int'(tec), 0, "tec cleared");
        check(  "R7", int'(rec), 0, "rec cleared");
        check(  "R7", int'(state), 0, "active after recovery");

        // Broad sweep, all inputs together, shifting bias per phase
        do_reset();
        begin
            logic [31:0] lf = 32'h1ACE_B00C;
            for (int p = 0; p < 10; p++) begin
                for (int c = 0; c < 2000; c++) begin
                    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                    step(int'(lf[3:0]) < p, int'(lf[11:8]) < 16 - p,
                         lf[7:4] < 4'd8, lf[15:12] < 4'd6, lf[16]);
                    check_all("R1/R2/R3/R6/R7/R8");
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule